// File: doc/BRIEF.md
# Byte Serdes With Loopback Muxing

This block converts byte-wide words into a bit-serial stream and back again for a set of independent lanes that all run off one fast bit clock. Transmit and receive each have a divide-by-W counter (W is 8 by default). Each counter has its own active-low reset, so the byte clocks it produces can be brought into a known phase against an external reference. Each counter runs from its reset state, and the matching byte clock rises on the first falling edge of the fast clock after the reset is released. The transmit byte clock tells upstream logic when the next word is taken. Each lane's receive byte clock comes out with its deserialized word.

A receive lane takes its bits from its own serial input pin or from its own transmit serializer. Each lane has a loopback bit, and a global loopback input forces every lane into loopback. A boundary-scan enable replaces every serial output pin with a per-lane scan value, and a monitor output always shows the serial input pins. A per-lane power-down input stops a receiver. The fast clock is a plain input. Clock synthesis, clock recovery and the analog pad buffers are outside this block.

Top module: `byte_serdes_loop`

## Requirements
- R1: `tx_bclk` is low while `rst` is high or `tx_div_rst_n` is low. The first rising `clk` edge that samples `tx_div_rst_n` high is the release edge, and `tx_bclk` rises on the falling edge that follows it. After that it repeats with a period of W `clk` cycles, high for the first W/2 cycles of each period.
- R2: `rx_bclk` behaves like `tx_bclk` but follows `rx_div_rst_n`. The receive divider is reset and released independently, and resetting it leaves `tx_bclk` running.
- R3: A lane's word is taken from `tx_word` at the release edge and then at every W-th rising edge. It leaves on the serial stream most-significant bit first, one bit per `clk` cycle, with bit W-1 present during the first cycle in which `tx_bclk` is high.
- R4: A receiver samples its input on the W rising edges that follow each word boundary of the receive divider. The first of these bits lands in bit W-1 of `rx_word`. The word appears after the last of these edges and stays stable across the next rising edge of `rx_bclk`.
- R5: With `loop_lane[i]` high, lane i receives its own serializer bit stream and ignores `ser_in[i]`. With both dividers released on the same edge, the word taken at one transmit boundary shows up on `rx_word` one byte period later.
- R6: `loop_all` high puts every lane into loopback, whatever `loop_lane` holds.
- R7: With `scan_en` high, `ser_out[i]` equals `scan_val[i]`. The serializers keep running, and loopback still receives serializer data rather than the scan value.
- R8: `pad_mon` always equals `ser_in`, including while lanes are in loopback.
- R9: While `rx_pd[i]` is high, lane i's `rx_word` is zero from the next rising edge and `rx_bclk[i]` is low. Other lanes are unaffected.
- R10: `rst` (synchronous, active-high) clears every byte clock, every received word and every serializer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| tx_div_rst_n | input | 1 | Active-low reset of the transmit divider |
| rx_div_rst_n | input | 1 | Active-low reset of the receive divider |
| tx_word | input | NUM_CH*W | Words to transmit, lane i at bits [i*W +: W] |
| tx_bclk | output | 1 | Transmit byte clock |
| ser_out | output | NUM_CH | Serial output pins |
| ser_in | input | NUM_CH | Serial input pins |
| pad_mon | output | NUM_CH | Monitor copy of the serial input pins |
| loop_lane | input | NUM_CH | Per-lane loopback enable |
| loop_all | input | 1 | Global loopback override |
| scan_en | input | 1 | Boundary-scan drive enable for the output pins |
| scan_val | input | NUM_CH | Boundary-scan values for the output pins |
| rx_pd | input | NUM_CH | Per-lane receiver power-down |
| rx_word | output | NUM_CH*W | Received words, lane i at bits [i*W +: W] |
| rx_bclk | output | NUM_CH | Per-lane receive byte clocks |

## Verification
The byte clocks come from falling-edge registers, while the divider state they read and the received words change on rising edges. The properties therefore assume that every input changes at most once per cycle, between the edges, and never glitches across a falling edge. The bench drives stimulus only 3 ns after a rising edge or 15 ns after it, and it never touches a divider reset near an edge. It holds each divider reset for at least four fast cycles. It releases both dividers together, so loopback words return on a known boundary. When the receive divider is re-released on its own, the bench checks only the receive clock phase and no word contents.

// File: rtl/serdes_loop_pkg.sv
package serdes_loop_pkg;

    // Divider status handed from a divider to the lanes it paces.
    typedef struct packed {
        logic wrap;     // counter sits on its last position: word boundary
        logic hi_half;  // counter is in the first half of the period
        logic live;     // divider has run at least one edge since release
    } div_state_t;

    // Where a receive lane takes its serial bits from.
    typedef enum logic {
        SRC_PAD  = 1'b0,
        SRC_LOOP = 1'b1
    } rx_src_e;

    // The global loopback wins over the lane bit; either selects loopback.
    function automatic rx_src_e pick_src(input logic glob, input logic lane);
        return (glob || lane) ? SRC_LOOP : SRC_PAD;
    endfunction

endpackage

// File: rtl/serdes_bclk_div.sv
module serdes_bclk_div
    import serdes_loop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       div_rst_n,
    output div_state_t state
);

    localparam int             CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0]  LAST = CW'(W - 1);
    localparam logic [CW-1:0]  HALF = CW'(W / 2);

    logic [CW-1:0] cnt;
    logic          live;

    // Held on the last position during reset, so the release edge starts at zero.
    always_ff @(posedge clk) begin
        if (rst || !div_rst_n) begin
            cnt  <= LAST;
            live <= 1'b0;
        end else begin
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            live <= 1'b1;
        end
    end

    assign state.wrap    = (cnt == LAST);
    assign state.hi_half = (cnt < HALF);
    assign state.live    = live;

endmodule

// File: rtl/serdes_tx_lane.sv
module serdes_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_in,
    output logic         tx_bit
);

    logic [W-1:0] sh;

    // Most significant bit leaves first.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= word_in;
        end else begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign tx_bit = sh[W-1];

endmodule

// File: rtl/serdes_rx_lane.sv
module serdes_rx_lane
    import serdes_loop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pd,
    input  div_state_t   dstate,
    input  logic         rx_bit,
    output logic [W-1:0] word_out,
    output logic         bclk_out
);

    logic [W-1:0] sh;
    logic [W-1:0] next_sh;

    assign next_sh = {sh[W-2:0], rx_bit};

    // Shift register freezes while powered down.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (!pd) begin
            sh <= next_sh;
        end
    end

    // The word completes on the edge where the divider sits on its boundary.
    always_ff @(posedge clk) begin
        if (rst || pd) begin
            word_out <= '0;
        end else if (dstate.wrap && dstate.live) begin
            word_out <= next_sh;
        end
    end

    // Byte clock launched on the falling edge, half a bit after the count moves.
    always_ff @(negedge clk) begin
        if (rst || pd) begin
            bclk_out <= 1'b0;
        end else begin
            bclk_out <= dstate.hi_half;
        end
    end

endmodule

// File: rtl/byte_serdes_loop.sv
module byte_serdes_loop
    import serdes_loop_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_div_rst_n,
    input  logic                rx_div_rst_n,
    input  logic [NUM_CH*W-1:0] tx_word,
    output logic                tx_bclk,
    output logic [NUM_CH-1:0]   ser_out,
    input  logic [NUM_CH-1:0]   ser_in,
    output logic [NUM_CH-1:0]   pad_mon,
    input  logic [NUM_CH-1:0]   loop_lane,
    input  logic                loop_all,
    input  logic                scan_en,
    input  logic [NUM_CH-1:0]   scan_val,
    input  logic [NUM_CH-1:0]   rx_pd,
    output logic [NUM_CH*W-1:0] rx_word,
    output logic [NUM_CH-1:0]   rx_bclk
);

    div_state_t        tx_state;
    div_state_t        rx_state;
    logic [NUM_CH-1:0] tx_raw;
    logic [NUM_CH-1:0] rx_feed;

    serdes_bclk_div #(.W(W)) u_tx_div (
        .clk      (clk),
        .rst      (rst),
        .div_rst_n(tx_div_rst_n),
        .state    (tx_state)
    );

    serdes_bclk_div #(.W(W)) u_rx_div (
        .clk      (clk),
        .rst      (rst),
        .div_rst_n(rx_div_rst_n),
        .state    (rx_state)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            tx_bclk <= 1'b0;
        end else begin
            tx_bclk <= tx_state.hi_half;
        end
    end

    assign pad_mon = ser_in;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        rx_src_e lane_src;

        serdes_tx_lane #(.W(W)) u_tx (
            .clk    (clk),
            .rst    (rst),
            .load   (tx_state.wrap),
            .word_in(tx_word[ch*W +: W]),
            .tx_bit (tx_raw[ch])
        );

        assign lane_src    = pick_src(loop_all, loop_lane[ch]);
        assign rx_feed[ch] = (lane_src == SRC_LOOP) ? tx_raw[ch] : ser_in[ch];
        assign ser_out[ch] = scan_en ? scan_val[ch] : tx_raw[ch];

        serdes_rx_lane #(.W(W)) u_rx (
            .clk     (clk),
            .rst     (rst),
            .pd      (rx_pd[ch]),
            .dstate  (rx_state),
            .rx_bit  (rx_feed[ch]),
            .word_out(rx_word[ch*W +: W]),
            .bclk_out(rx_bclk[ch])
        );
    end

endmodule

// File: rtl/serdes_loop_chk.sv
module serdes_loop_chk #(
    parameter int NUM_CH = 4,
    parameter int W      = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                tx_div_rst_n,
    input logic                rx_div_rst_n,
    input logic [NUM_CH*W-1:0] tx_word,
    input logic                tx_bclk,
    input logic [NUM_CH-1:0]   ser_out,
    input logic                scan_en,
    input logic [NUM_CH-1:0]   rx_pd,
    input logic [NUM_CH*W-1:0] rx_word,
    input logic [NUM_CH-1:0]   rx_bclk
);

    localparam int            SW      = $clog2(W) + 2;
    localparam logic [SW-1:0] SPAN    = SW'(W);
    localparam logic [W-1:0]  TOP_BIT = W'(1) << (W - 1);

    logic          prev_bclk;
    logic          seen_rise;
    logic [SW-1:0] since;

    // Rising edges counted between transmit byte clock rises.
    always_ff @(posedge clk) begin
        if (rst || !tx_div_rst_n) begin
            prev_bclk <= 1'b0;
            seen_rise <= 1'b0;
            since     <= '0;
        end else begin
            prev_bclk <= tx_bclk;
            if (tx_bclk && !prev_bclk) begin
                seen_rise <= 1'b1;
                since     <= SW'(1);
            end else if (since != '1) begin
                since <= since + 1'b1;
            end
        end
    end

    AST_TX_BCLK_HELD: assert property (@(posedge clk) disable iff (rst) (!tx_div_rst_n && $past(!tx_div_rst_n)) |-> !tx_bclk); // R1
    AST_TX_BCLK_PERIOD: assert property (@(posedge clk) disable iff (rst) (tx_bclk && !prev_bclk && seen_rise) |-> (since == SPAN)); // R1
    AST_RX_BCLK_HELD: assert property (@(posedge clk) disable iff (rst) (!rx_div_rst_n && $past(!rx_div_rst_n)) |-> (rx_bclk == '0)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_TX_MSB_FIRST: assert property (@(posedge clk) disable iff (rst) ($rose(tx_bclk) && !scan_en) |-> (ser_out[c] == ($past(tx_word[c*W +: W]) >= TOP_BIT))); // R3
        AST_PD_WORD_ZERO: assert property (@(posedge clk) disable iff (rst) $past(rx_pd[c]) |-> (rx_word[c*W +: W] == '0)); // R9
        AST_PD_BCLK_LOW: assert property (@(posedge clk) disable iff (rst) (rx_pd[c] && $past(rx_pd[c])) |-> !rx_bclk[c]); // R9
    end

endmodule

bind byte_serdes_loop serdes_loop_chk #(.NUM_CH(NUM_CH), .W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_div_rst_n(tx_div_rst_n),
    .rx_div_rst_n(rx_div_rst_n),
    .tx_word     (tx_word),
    .tx_bclk     (tx_bclk),
    .ser_out     (ser_out),
    .scan_en     (scan_en),
    .rx_pd       (rx_pd),
    .rx_word     (rx_word),
    .rx_bclk     (rx_bclk)
);

// File: tb/byte_serdes_loop_test.sv
module byte_serdes_loop_test;

    localparam int NC = 4;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_div_rst_n;
    logic          rx_div_rst_n;
    logic [NC*W-1:0] tx_word;
    logic          tx_bclk;
    logic [NC-1:0] ser_out;
    logic [NC-1:0] ser_in;
    logic [NC-1:0] pad_mon;
    logic [NC-1:0] loop_lane;
    logic          loop_all;
    logic          scan_en;
    logic [NC-1:0] scan_val;
    logic [NC-1:0] rx_pd;
    logic [NC*W-1:0] rx_word;
    logic [NC-1:0] rx_bclk;

    always #10 clk = ~clk;

    byte_serdes_loop #(.NUM_CH(NC), .W(W)) uut (
        .clk(clk), .rst(rst), .tx_div_rst_n(tx_div_rst_n), .rx_div_rst_n(rx_div_rst_n),
        .tx_word(tx_word), .tx_bclk(tx_bclk), .ser_out(ser_out), .ser_in(ser_in),
        .pad_mon(pad_mon), .loop_lane(loop_lane), .loop_all(loop_all), .scan_en(scan_en),
        .scan_val(scan_val), .rx_pd(rx_pd), .rx_word(rx_word), .rx_bclk(rx_bclk)
    );

    int k;
    int checks;
    int errors;
    int rx_base;
    bit rx_held;
    bit rx_pat_on;
    bit rx_word_on;
    bit done;

    function automatic logic [7:0] pbyte(input int m, input int c);
        return 8'((m * 29 + c * 67 + 3) % 256);
    endfunction

    function automatic logic [7:0] qbyte(input int m, input int c);
        return 8'((m * 53 + c * 17 + 200) % 256);
    endfunction

    function automatic logic sbit(input int n, input int c);
        return 1'(((n + c) * 13 >> 2) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at k=%0d", req, act, exp, k);
        end
    endtask

    // One fast cycle: rising edge, drive at +3 ns, return at +15 ns.
    task automatic tick();
        @(posedge clk);
        k++;
        #3;
        if (k % 8 == 1) begin
            for (int c = 0; c < NC; c++) tx_word[c*W +: W] = pbyte(k / 8 + 1, c);
        end
        for (int c = 0; c < NC; c++) begin
            logic [7:0] qb;
            qb = qbyte(k / 8, c);
            ser_in[c]   = qb[7 - (k % 8)];
            scan_val[c] = sbit(k, c);
        end
        #12;
    endtask

    task automatic check_cycle();
        logic exp_b;
        logic [7:0] pb;
        exp_b = ((k % 8) < 4);
        chk(tx_bclk == exp_b, "R1", int'(tx_bclk), int'(exp_b));
        chk(pad_mon == ser_in, "R8", int'(pad_mon), int'(ser_in));
        for (int c = 0; c < NC; c++) begin
            logic exp_o;
            pb = pbyte(k / 8, c);
            exp_o = scan_en ? scan_val[c] : pb[7 - (k % 8)];
            chk(ser_out[c] == exp_o, scan_en ? "R7" : "R3", int'(ser_out[c]), int'(exp_o));
            if (rx_pd[c]) begin
                chk(rx_bclk[c] == 1'b0, "R9", int'(rx_bclk[c]), 0);
                chk(rx_word[c*W +: W] == 8'h00, "R9", int'(rx_word[c*W +: W]), 0);
            end else begin
                if (rx_held) begin
                    chk(rx_bclk[c] == 1'b0, "R2", int'(rx_bclk[c]), 0);
                end else if (rx_pat_on) begin
                    logic exp_r;
                    exp_r = (((k - rx_base) % 8) < 4);
                    chk(rx_bclk[c] == exp_r, "R2", int'(rx_bclk[c]), int'(exp_r));
                end
                if (rx_word_on && (k % 8 == 0) && (k >= 8)) begin
                    logic [7:0] exp_w;
                    string tag;
                    if (loop_all) begin
                        exp_w = pbyte(k / 8 - 1, c);
                        tag = scan_en ? "R7" : "R6";
                    end else if (loop_lane[c]) begin
                        exp_w = pbyte(k / 8 - 1, c);
                        tag = "R5";
                    end else begin
                        exp_w = qbyte(k / 8 - 1, c);
                        tag = "R4";
                    end
                    chk(rx_word[c*W +: W] == exp_w, tag, int'(rx_word[c*W +: W]), int'(exp_w));
                end
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check_cycle();
        end
    endtask

    initial begin
        checks = 0; errors = 0; done = 0; k = -1; rx_base = 0;
        rx_held = 0; rx_pat_on = 0; rx_word_on = 0;
        rst = 1'b1; tx_div_rst_n = 1'b0; rx_div_rst_n = 1'b0;
        tx_word = '0; ser_in = '0; loop_lane = '0; loop_all = 1'b0;
        scan_en = 1'b0; scan_val = '0; rx_pd = '0;

        // R10: reset state
        repeat (5) @(posedge clk);
        #15;
        chk(tx_bclk == 1'b0, "R10", int'(tx_bclk), 0);
        chk(rx_bclk == '0, "R10", int'(rx_bclk), 0);
        chk(rx_word == '0, "R10", int'(rx_word), 0);
        chk(ser_out == '0, "R10", int'(ser_out), 0);

        // Dividers still held: byte clocks stay low (R1, R2)
        @(posedge clk);
        #3 rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #15;
            chk(tx_bclk == 1'b0, "R1", int'(tx_bclk), 0);
            chk(rx_bclk == '0, "R2", int'(rx_bclk), 0);
        end

        // Release both dividers together; next rising edge is the release edge.
        for (int c = 0; c < NC; c++) tx_word[c*W +: W] = pbyte(0, c);
        loop_all = 1'b1;
        rx_pat_on = 1; rx_word_on = 1;
        tx_div_rst_n = 1'b1;
        rx_div_rst_n = 1'b1;

        // Global loopback, pads carry a different stream (R6)
        run(49);
        // Per-lane loopback on lanes 0 and 2 (R5, R4)
        loop_all = 1'b0; loop_lane = 4'b0101;
        run(64);
        // Scan drives pins, loopback still sees serializer data (R7)
        scan_en = 1'b1; loop_all = 1'b1;
        run(48);
        // Power-down on lanes 1 and 3 (R9)
        scan_en = 1'b0; loop_all = 1'b0; loop_lane = 4'b0011; rx_pd = 4'b1010;
        run(48);
        // Receive divider reset alone while transmit keeps running (R2)
        rx_pd = '0; loop_all = 1'b1; rx_word_on = 0;
        rx_div_rst_n = 1'b0; rx_held = 1;
        run(6);
        rx_div_rst_n = 1'b1; rx_held = 0; rx_base = k + 1;
        run(24);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule